// File: doc/BRIEF.md
# Two-Line Prioritised Interrupt Router

This block gathers a parameterised set of peripheral request lines and reduces them to two processor request outputs: a normal line and a fast line. Software gives every source an enable bit, a priority value, a class bit that steers it onto one of the two lines, and a trigger mode (level or rising edge). Each line is asserted while at least one enabled, pending and not-yet-active source of its class exists.

The service routine reads the acknowledge register of its line to learn which source to handle, without scanning the sources itself. That read returns the most urgent eligible source and marks it active. An active source cannot be returned again until its number is written to the end-of-service register. A source captured in edge mode stays pending after its input falls, until an acknowledge or a pending-clear write removes it.

All registers are 32-bit words on a byte address with a one-cycle read latency. Offsets: 0x00 enable-set (reads back the enable mask), 0x04 enable-clear (also reads back the enable mask), 0x08 pending-clear (write-only), 0x0C class mask, 0x10 trigger mask, 0x14 normal acknowledge, 0x18 fast acknowledge, 0x1C end-of-service (write-only), and 0x40 + 4*n the priority of source n.

Top module: `irc_top`

## Requirements
- R1: While reset is asserted, and right after it, both request outputs are low, read data is 0, and every enable, class, trigger, priority and active bit is 0.
- R2: A source in level mode (trigger bit 0) is pending while its input is high, as seen after one synchronising register. It stops being pending once the input falls.
- R3: A source in edge mode (trigger bit 1) becomes pending on a rising edge of its synchronised input. It stays pending after the input falls.
- R4: Writing 1s to offset 0x00 sets enable bits and writing 1s to 0x04 clears them. A disabled source never drives either request output. The enable mask reads back at 0x00 and 0x04.
- R5: Class bit n (offset 0x0C) routes source n to the fast output when 1 and to the normal output when 0, and to no other output.
- R6: A read of 0x14 (normal) or 0x18 (fast) returns, in bits [ID_W-1:0], the eligible source of that class with the largest priority value. On a tie the lowest source number wins. The returned source is marked active.
- R7: When no source of that class is eligible, the acknowledge read returns the idle code 2**ID_W-1 (15 with 8 sources) and changes no state.
- R8: An active source neither drives an output nor is returned again until its number is written to offset 0x1C. Writes there of numbers at or above the source count have no effect.
- R9: Acknowledging an edge-mode source clears its captured edge, so it is not pending again until a new rising edge.
- R10: Writing 1s to offset 0x08 clears captured edges of those sources. It does not affect level-mode sources, which stay pending while their input is high.
- R11: The priority register of source n at 0x40+4n stores and reads back bits [PRIO_W-1:0] of the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Peripheral request lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Byte address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid the cycle after the read strobe |
| nreq_o | output | 1 | Normal request to the processor |
| freq_o | output | 1 | Fast request to the processor |

## Verification
The assertions assume that the strobes and the address are free of X once reset is released. They also assume that a read strobe at an acknowledge offset is a real service action, because it changes state. The stimulus drives all register inputs at the falling edge from defined values. It picks addresses only from the defined map and keeps end-of-service numbers within the 4-bit field range, including out-of-range numbers on purpose. Source lines toggle freely, so edge capture races against acknowledge and pending-clear in the same cycle.

// File: rtl/irc_pkg.sv
package irc_pkg;
   // register offsets (byte addresses)
   localparam logic [7:0] OFS_EN_SET   = 8'h00;
   localparam logic [7:0] OFS_EN_CLR   = 8'h04;
   localparam logic [7:0] OFS_PEND_CLR = 8'h08;
   localparam logic [7:0] OFS_CLASS    = 8'h0C;
   localparam logic [7:0] OFS_TRIG     = 8'h10;
   localparam logic [7:0] OFS_ACK_N    = 8'h14;
   localparam logic [7:0] OFS_ACK_F    = 8'h18;
   localparam logic [7:0] OFS_EOI      = 8'h1C;
   localparam logic [7:0] OFS_PRIO     = 8'h40;

   // index of the two request lines
   typedef enum logic {LINE_NORM = 1'b0, LINE_FAST = 1'b1} line_e;
endpackage

// File: rtl/irc_sync_edge.sv
module irc_sync_edge #(
   parameter bit SYNC_IN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_i,
   output logic lvl_o,
   output logic rise_o
);
   logic prev_q;

   generate
      if (SYNC_IN) begin : g_sync
         logic lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= 1'b0;
            else        lvl_q <= src_i;
         end
         assign lvl_o = lvl_q;
      end else begin : g_direct
         assign lvl_o = src_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_o;
   end

   assign rise_o = lvl_o & ~prev_q;
endmodule

// File: rtl/irc_arbiter.sv
module irc_arbiter #(
   parameter int NUM_SRC = 8,
   parameter int PRIO_W  = 3,
   parameter int ID_W    = 4
) (
   input  logic [NUM_SRC-1:0]        req_i,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
   output logic                      any_o,
   output logic [ID_W-1:0]           id_o
);
   logic [PRIO_W-1:0] best;

   // linear scan: strictly-greater keeps the lowest index on ties
   always_comb begin
      any_o = 1'b0;
      id_o  = '0;
      best  = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (req_i[i] && (!any_o || prio_i[i*PRIO_W +: PRIO_W] > best)) begin
            any_o = 1'b1;
            id_o  = ID_W'(i);
            best  = prio_i[i*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/irc_top.sv
module irc_top
   import irc_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int PRIO_W  = 3,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter bit SYNC_IN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               reg_wr_i,
   input  logic               reg_rd_i,
   input  logic [ADDR_W-1:0]  reg_addr_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   output logic               nreq_o,
   output logic               freq_o
);
   localparam int ID_W = $clog2(NUM_SRC) + 1;
   localparam logic [ID_W-1:0] IDLE_ID = '1;

   generate
      if (NUM_SRC < 2 || NUM_SRC > DATA_W)
         $error("irc_top: NUM_SRC must lie in 2..DATA_W");
      if (PRIO_W < 1 || PRIO_W > DATA_W)
         $error("irc_top: PRIO_W out of range");
      if (ADDR_W < 8 || (int'(OFS_PRIO) + 4*NUM_SRC) > (1 << ADDR_W))
         $error("irc_top: ADDR_W too small for the register map");
   endgenerate

   function automatic logic [ADDR_W-1:0] prio_addr(input int n);
      return ADDR_W'(int'(OFS_PRIO) + 4*n);
   endfunction

   logic [NUM_SRC-1:0] lvl, rise, latch_q, en_q, cls_q, trg_q, act_q;
   logic [NUM_SRC-1:0] pend, elig, take, eoi_mask, pclr;
   logic [PRIO_W-1:0]  prio_q [NUM_SRC];
   logic [NUM_SRC*PRIO_W-1:0] prio_flat;
   logic [1:0]         win_any;
   logic [ID_W-1:0]    win_id [2];
   logic [1:0]         ack_rd;
   logic [DATA_W-1:0]  rd_val;

   // per-source input stage
   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         irc_sync_edge #(.SYNC_IN(SYNC_IN)) u_se (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (src_i[i]),
            .lvl_o  (lvl[i]),
            .rise_o (rise[i])
         );
         assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               prio_q[i] <= '0;
            else if (reg_wr_i && reg_addr_i == prio_addr(i))
               prio_q[i] <= reg_wdata_i[PRIO_W-1:0];
         end
      end
   endgenerate

   assign pend = (trg_q & latch_q) | (~trg_q & lvl);
   assign elig = pend & en_q & ~act_q;

   // one arbiter per request line
   generate
      for (genvar c = 0; c < 2; c++) begin : g_line
         logic [NUM_SRC-1:0] req;
         assign req = elig & ((c == int'(LINE_FAST)) ? cls_q : ~cls_q);
         irc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
            .req_i  (req),
            .prio_i (prio_flat),
            .any_o  (win_any[c]),
            .id_o   (win_id[c])
         );
      end
   endgenerate

   assign nreq_o = win_any[LINE_NORM];
   assign freq_o = win_any[LINE_FAST];

   assign ack_rd[LINE_NORM] = reg_rd_i && reg_addr_i == ADDR_W'(OFS_ACK_N);
   assign ack_rd[LINE_FAST] = reg_rd_i && reg_addr_i == ADDR_W'(OFS_ACK_F);

   always_comb begin
      take     = '0;
      eoi_mask = '0;
      for (int c = 0; c < 2; c++)
         if (ack_rd[c] && win_any[c]) take[win_id[c]] = 1'b1;
      for (int i = 0; i < NUM_SRC; i++)
         if (reg_wr_i && reg_addr_i == ADDR_W'(OFS_EOI) && reg_wdata_i == DATA_W'(i))
            eoi_mask[i] = 1'b1;
   end

   assign pclr = (reg_wr_i && reg_addr_i == ADDR_W'(OFS_PEND_CLR))
                 ? reg_wdata_i[NUM_SRC-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         cls_q   <= '0;
         trg_q   <= '0;
         latch_q <= '0;
         act_q   <= '0;
      end else begin
         if (reg_wr_i && reg_addr_i == ADDR_W'(OFS_EN_SET))
            en_q <= en_q | reg_wdata_i[NUM_SRC-1:0];
         else if (reg_wr_i && reg_addr_i == ADDR_W'(OFS_EN_CLR))
            en_q <= en_q & ~reg_wdata_i[NUM_SRC-1:0];
         if (reg_wr_i && reg_addr_i == ADDR_W'(OFS_CLASS))
            cls_q <= reg_wdata_i[NUM_SRC-1:0];
         if (reg_wr_i && reg_addr_i == ADDR_W'(OFS_TRIG))
            trg_q <= reg_wdata_i[NUM_SRC-1:0];
         // a new edge in the same cycle as a clear survives
         latch_q <= (latch_q & ~pclr & ~take) | (rise & trg_q);
         act_q   <= (act_q | take) & ~eoi_mask;
      end
   end

   // read mux
   always_comb begin
      rd_val = '0;
      if (reg_addr_i == ADDR_W'(OFS_EN_SET) || reg_addr_i == ADDR_W'(OFS_EN_CLR))
         rd_val = DATA_W'(en_q);
      else if (reg_addr_i == ADDR_W'(OFS_CLASS))
         rd_val = DATA_W'(cls_q);
      else if (reg_addr_i == ADDR_W'(OFS_TRIG))
         rd_val = DATA_W'(trg_q);
      else if (ack_rd[LINE_NORM])
         rd_val = DATA_W'(win_any[LINE_NORM] ? win_id[LINE_NORM] : IDLE_ID);
      else if (ack_rd[LINE_FAST])
         rd_val = DATA_W'(win_any[LINE_FAST] ? win_id[LINE_FAST] : IDLE_ID);
      for (int i = 0; i < NUM_SRC; i++)
         if (reg_addr_i == prio_addr(i)) rd_val = DATA_W'(prio_q[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        reg_rdata_o <= '0;
      else if (reg_rd_i) reg_rdata_o <= rd_val;
   end
endmodule

// File: rtl/irc_chk.sv
module irc_chk
   import irc_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_wr_i,
   input logic               reg_rd_i,
   input logic [ADDR_W-1:0]  reg_addr_i,
   input logic [DATA_W-1:0]  reg_wdata_i,
   input logic [DATA_W-1:0]  reg_rdata_o,
   input logic               nreq_o,
   input logic               freq_o,
   input logic [NUM_SRC-1:0] en_q,
   input logic [NUM_SRC-1:0] act_q
);
   localparam int ID_W = $clog2(NUM_SRC) + 1;
   localparam logic [DATA_W-1:0] IDLE_W = DATA_W'((1 << ID_W) - 1);

   logic rd_n, rd_f, eoi_wr;
   assign rd_n   = reg_rd_i && reg_addr_i == ADDR_W'(OFS_ACK_N);
   assign rd_f   = reg_rd_i && reg_addr_i == ADDR_W'(OFS_ACK_F);
   assign eoi_wr = reg_wr_i && reg_addr_i == ADDR_W'(OFS_EOI);

   // R1
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!nreq_o && !freq_o && reg_rdata_o == '0));

   // R4
   a_r4_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> (!nreq_o && !freq_o));

   // R7
   a_r7_idle_norm: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_n && !nreq_o) |=> reg_rdata_o == IDLE_W);
   a_r7_idle_fast: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_f && !freq_o) |=> reg_rdata_o == IDLE_W);

   // R6
   a_r6_ack_norm_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_n && nreq_o) |=> reg_rdata_o < DATA_W'(NUM_SRC));
   a_r6_ack_fast_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_f && freq_o) |=> reg_rdata_o < DATA_W'(NUM_SRC));

   // R8
   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_act
         a_r8_active_only_by_ack: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_n && !rd_f && !act_q[i]) |=> !act_q[i]);
         a_r8_eoi_releases: assert property (@(posedge clk) disable iff (!rst_n)
            (eoi_wr && reg_wdata_i == DATA_W'(i)) |=> !act_q[i]);
      end
   endgenerate
endmodule

bind irc_top irc_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr_i    (reg_wr_i),
   .reg_rd_i    (reg_rd_i),
   .reg_addr_i  (reg_addr_i),
   .reg_wdata_i (reg_wdata_i),
   .reg_rdata_o (reg_rdata_o),
   .nreq_o      (nreq_o),
   .freq_o      (freq_o),
   .en_q        (en_q),
   .act_q       (act_q)
);

// File: tb/irc_top_tb.sv
`timescale 1ns/1ps
module irc_top_tb_top;
   localparam int NS = 8;
   localparam int IDLE = 15;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src = '0;
   logic          wr = 1'b0, rd = 1'b0;
   logic [7:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          nreq, freq;

   int checks = 0, errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   irc_top #(.NUM_SRC(NS), .PRIO_W(3), .ADDR_W(8), .DATA_W(32)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_i(src),
      .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .nreq_o(nreq), .freq_o(freq)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [NS-1:0] m_sync, m_prev, m_latch, m_en, m_cls, m_trg, m_act;
   int            m_prio [NS];
   logic [31:0]   m_rdata;
   bit            m_live = 0;

   function automatic int pick(input logic [NS-1:0] e, input bit fast);
      int w = -1;
      for (int i = 0; i < NS; i++)
         if (e[i] && (m_cls[i] == fast) && (w < 0 || m_prio[i] > m_prio[w])) w = i;
      return w;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sync = '0; m_prev = '0; m_latch = '0; m_en = '0; m_cls = '0;
         m_trg = '0; m_act = '0; m_rdata = '0;
         for (int i = 0; i < NS; i++) m_prio[i] = 0;
      end else begin
         logic [NS-1:0] pend, elig, take, eoi, pclr, n_en, n_cls, n_trg;
         int wn, wf;
         pend = (m_trg & m_latch) | (~m_trg & m_sync);
         elig = pend & m_en & ~m_act;
         wn = pick(elig, 1'b0);
         wf = pick(elig, 1'b1);
         take = '0; eoi = '0; pclr = '0;
         n_en = m_en; n_cls = m_cls; n_trg = m_trg;
         if (rd) begin
            case (addr)
               8'h00, 8'h04: m_rdata = 32'(m_en);
               8'h0C: m_rdata = 32'(m_cls);
               8'h10: m_rdata = 32'(m_trg);
               8'h14: begin m_rdata = (wn < 0) ? IDLE : wn; if (wn >= 0) take[wn] = 1; end
               8'h18: begin m_rdata = (wf < 0) ? IDLE : wf; if (wf >= 0) take[wf] = 1; end
               default: begin
                  m_rdata = '0;
                  if (addr >= 8'h40 && addr < 8'h40 + 4*NS && addr[1:0] == 2'b00)
                     m_rdata = m_prio[(addr - 8'h40) / 4];
               end
            endcase
         end
         if (wr) begin
            case (addr)
               8'h00: n_en = m_en | wdata[NS-1:0];
               8'h04: n_en = m_en & ~wdata[NS-1:0];
               8'h08: pclr = wdata[NS-1:0];
               8'h0C: n_cls = wdata[NS-1:0];
               8'h10: n_trg = wdata[NS-1:0];
               8'h1C: if (wdata < NS) eoi[wdata] = 1;
               default:
                  if (addr >= 8'h40 && addr < 8'h40 + 4*NS && addr[1:0] == 2'b00)
                     m_prio[(addr - 8'h40) / 4] = wdata[2:0];
            endcase
         end
         m_latch = (m_latch & ~pclr & ~take) | (m_sync & ~m_prev & m_trg);
         m_act   = (m_act | take) & ~eoi;
         m_en = n_en; m_cls = n_cls; m_trg = n_trg;
         m_prev = m_sync;
         m_sync = src;
      end
      m_live = 1;
   end

   // compare every cycle, just before the next rising edge
   always @(negedge clk) begin
      #8;
      if (m_live && !done) begin
         logic [NS-1:0] pend, elig;
         pend = (m_trg & m_latch) | (~m_trg & m_sync);
         elig = pend & m_en & ~m_act;
         chk(nreq == (pick(elig, 1'b0) >= 0), "R5 normal line vs model", nreq, pick(elig, 1'b0) >= 0);
         chk(freq == (pick(elig, 1'b1) >= 0), "R5 fast line vs model", freq, pick(elig, 1'b1) >= 0);
         chk(rdata == m_rdata, "R6 read data vs model", rdata, m_rdata);
      end
   end

   // ---------------- stimulus ----------------
   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wreg(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); wr = 1; addr = a; wdata = d;
      @(negedge clk); wr = 0;
   endtask

   task automatic rreg(input logic [7:0] a, input logic [31:0] exp, input string req);
      @(negedge clk); rd = 1; addr = a;
      @(negedge clk); rd = 0;
      #1 chk(rdata == exp, req, rdata, exp);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      cyc(3);
      // R1: reset state
      #1 chk(!nreq && !freq, "R1 outputs low in reset", {nreq, freq}, 0);
      chk(rdata == 0, "R1 read data zero in reset", rdata, 0);
      @(negedge clk); rst_n = 1;
      rreg(8'h00, 0, "R1 enables zero after reset");
      rreg(8'h4C, 0, "R1 priority zero after reset");

      // R4: all sources raised but disabled
      src = '1; cyc(4);
      #1 chk(!nreq && !freq, "R4 disabled sources silent", {nreq, freq}, 0);

      wreg(8'h0C, 32'h40);          // source 6 on fast line
      wreg(8'h10, 32'h04);          // source 2 edge mode
      wreg(8'h44, 2);               // prio1 = 2
      wreg(8'h4C, 5);               // prio3 = 5
      wreg(8'h54, 5);               // prio5 = 5
      wreg(8'h58, 7);               // prio6 = 7
      wreg(8'h00, 32'h6E);
      rreg(8'h00, 32'h6E, "R4 enable mask readback");
      rreg(8'h04, 32'h6E, "R4 enable mask readback at clear offset");
      rreg(8'h4C, 5, "R11 priority readback");

      // R6 ordering with tie, R8 active suppression, R7 idle code
      rreg(8'h14, 3, "R6 tie goes to lower number");
      rreg(8'h14, 5, "R8 active source skipped");
      rreg(8'h14, 1, "R6 lower priority served last");
      rreg(8'h14, IDLE, "R7 idle code normal line");
      rreg(8'h18, 6, "R5 fast source on fast acknowledge");
      rreg(8'h18, IDLE, "R7 idle code fast line");
      wreg(8'h1C, 3);
      rreg(8'h14, 3, "R8 source returns after end-of-service");
      wreg(8'h1C, 9);
      rreg(8'h14, IDLE, "R8 out-of-range end-of-service ignored");
      #1 chk(!nreq, "R8 all active, normal line low", nreq, 0);

      // R3 / R9 edge capture
      src = '0;
      wreg(8'h1C, 1); wreg(8'h1C, 3); wreg(8'h1C, 5); wreg(8'h1C, 6);
      cyc(3);
      #1 chk(!nreq && !freq, "R2 level sources drop with input", {nreq, freq}, 0);
      @(negedge clk); src[2] = 1;
      @(negedge clk); src[2] = 0;
      cyc(3);
      #1 chk(nreq, "R3 edge held after input fell", nreq, 1);
      rreg(8'h14, 2, "R9 edge source acknowledged");
      wreg(8'h1C, 2);
      #1 chk(!nreq, "R9 edge cleared by acknowledge", nreq, 0);

      // R10 pending-clear
      @(negedge clk); src[2] = 1;
      @(negedge clk); src[2] = 0;
      cyc(3);
      #1 chk(nreq, "R3 second edge captured", nreq, 1);
      wreg(8'h08, 32'h04);
      #1 chk(!nreq, "R10 pending-clear drops edge", nreq, 0);
      @(negedge clk); src[1] = 1;
      cyc(2);
      #1 chk(nreq, "R2 level source pending", nreq, 1);
      wreg(8'h08, 32'h02);
      #1 chk(nreq, "R10 pending-clear ignores level source", nreq, 1);
      @(negedge clk); src[1] = 0;
      cyc(2);
      #1 chk(!nreq, "R2 level source released", nreq, 0);
      @(negedge clk); src[1] = 1;
      cyc(2);
      wreg(8'h04, 32'h02);
      #1 chk(!nreq, "R4 enable-clear masks source", nreq, 0);
      @(negedge clk); src = 8'h40;
      cyc(2);
      #1 chk(freq && !nreq, "R5 fast routing only", {nreq, freq}, 1);
      wreg(8'h40, 32'hFF);
      rreg(8'h40, 7, "R11 priority field width");

      // free-running mixed traffic against the model
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         src = NS'($urandom);
         wr = 0; rd = 0;
         case ($urandom_range(0, 9))
            0: begin wr = 1; addr = 8'h00; wdata = $urandom; end
            1: begin wr = 1; addr = 8'h04; wdata = $urandom_range(0, 3) == 0 ? $urandom : 0; end
            2: begin wr = 1; addr = 8'h08; wdata = $urandom; end
            3: begin wr = 1; addr = ($urandom_range(0, 1) == 1) ? 8'h0C : 8'h10; wdata = $urandom; end
            4: begin wr = 1; addr = 8'h40 + 4 * $urandom_range(0, NS - 1); wdata = $urandom; end
            5, 6: begin rd = 1; addr = ($urandom_range(0, 1) == 1) ? 8'h14 : 8'h18; end
            7: begin wr = 1; addr = 8'h1C; wdata = $urandom_range(0, 15); end
            8: begin rd = 1; addr = 8'h40 + 4 * $urandom_range(0, NS - 1); end
            default: begin rd = 1; addr = 8'h00; end
         endcase
         if ($urandom_range(0, 3) == 0) begin
            rd = 1; addr = ($urandom_range(0, 1) == 1) ? 8'h14 : 8'h18;
         end
      end
      @(negedge clk); wr = 0; rd = 0;
      cyc(2);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule